// File: doc/BRIEF.md
# Truth-Table Programmable 8-bit ALU

This block is the arithmetic and logic stage of a small 8-bit controller datapath. Every logical operation comes from one four-bit code that serves as the truth table of a Boolean function of two bits. For each bit position, the two operand bits pick one bit of that code. Arithmetic is a single addition through a generate/propagate carry chain. Before either path, each operand can be cleared, inverted or forced to all ones. That one adder therefore also gives subtraction (invert B, carry-in one), decrement (add 0xFF) and pass or negate forms.

The carry-in source is chosen per operation: zero, one, or the stored carry flag. A 16-bit addition is done as a plain add on the low bytes followed by an add-with-carry on the high bytes. The result and an 8-bit flag word are registered. The low nibble of the flag word is the status the block computes, and it is rewritten only when flag writing is enabled. The high nibble is sampled every cycle from four external user flag inputs.

Top module: `lut_alu`

## Requirements
- R1: While `rst` is high at a rising clock edge, `result` and `flags` become all zeros.
- R2: In logic mode (`arith`=0), bit i of `result` equals `fn[2*A'[i] + B'[i]]`, where A' and B' are the conditioned operands. The output appears one clock after the inputs are applied.
- R3: Each operand is conditioned independently. Clear alone gives 0x00, invert alone gives the bitwise complement, clear and invert together give 0xFF, and neither leaves the operand unchanged.
- R4: In arithmetic mode (`arith`=1), `result` = (A' + B' + cin) mod 256. The carry-in is set by `cin_mode`: 2'b00 gives 0, 2'b01 gives 1, and 2'b10 or 2'b11 gives the stored carry flag (`flags[0]`).
- R5: After an arithmetic operation with `flag_we`=1, `flags[0]` (carry) is the carry out of bit 7. `flags[3]` (overflow) is set when A'[7]==B'[7] and result[7] differs from them.
- R6: After any operation with `flag_we`=1, `flags[1]` (zero) is set exactly when the 8-bit result is 0x00, and `flags[2]` (sign) equals result bit 7.
- R7: After a logic operation with `flag_we`=1, the carry and overflow flags are 0.
- R8: With `flag_we`=0, `flags[3:0]` keep their previous value, while `result` still updates.
- R9: `flags[7:4]` take the value of `user_flags` at every clock edge, whatever `flag_we` is.
- R10: A plain add on the low bytes followed by an add-with-carry on the high bytes gives the correct 16-bit sum. Repeatedly adding 0xFF decrements by one and sets the zero flag when the value reaches 0x00.
- R11: Inverting B with carry-in 1 gives (A - B) mod 256, with carry set exactly when A >= B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 8 | Operand A |
| b_in | input | 8 | Operand B |
| a_clr | input | 1 | Clear operand A (with a_inv: set) |
| a_inv | input | 1 | Invert operand A |
| b_clr | input | 1 | Clear operand B (with b_inv: set) |
| b_inv | input | 1 | Invert operand B |
| fn | input | 4 | Truth-table code for logic mode |
| arith | input | 1 | 1 = add path, 0 = truth-table path |
| cin_mode | input | 2 | Carry-in source: 00 zero, 01 one, 1x stored carry |
| flag_we | input | 1 | Enables update of flags[3:0] |
| user_flags | input | 4 | External flags sampled into flags[7:4] |
| result | output | 8 | Registered result |
| flags | output | 8 | {user[3:0], overflow, sign, zero, carry} |

## Verification
The assertions assume that every control input is a defined 0 or 1 at each rising edge. They also assume that the stored carry read by a carry-in-from-flag operation is the one left by the previous flag-writing operation. The bench drives every input at the falling edge from one task, so each edge sees one fixed, fully defined operation. It keeps its own copy of the flag nibble, so chained and no-write operations are predicted from earlier results and never from design internals.

// File: rtl/lut_alu_pkg.sv
package lut_alu_pkg;
  localparam int FLG_C = 0;
  localparam int FLG_Z = 1;
  localparam int FLG_S = 2;
  localparam int FLG_V = 3;
  localparam int NSTAT = 4;

  typedef enum logic [1:0] {
    CIN_ZERO   = 2'b00,
    CIN_ONE    = 2'b01,
    CIN_STORED = 2'b10
  } cin_mode_e;
endpackage

// File: rtl/opnd_cond.sv
module opnd_cond #(
  parameter int W = 8
) (
  input  logic [W-1:0] d,
  input  logic         clr,
  input  logic         inv,
  output logic [W-1:0] q
);
  always_comb begin
    unique case ({clr, inv})
      2'b00:   q = d;
      2'b01:   q = ~d;
      2'b10:   q = '0;
      default: q = '1;
    endcase
  end
endmodule

// File: rtl/ttab_logic.sv
module ttab_logic #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [3:0]   fn,
  output logic [W-1:0] y
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign y[i] = fn[{a[i], b[i]}];
  end
endmodule

// File: rtl/gp_adder.sv
module gp_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W-1:0] gen, prop;
  logic [W:0]   cy;

  assign gen   = a & b;
  assign prop  = a ^ b;
  assign cy[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_chain
    assign cy[i+1] = gen[i] | (prop[i] & cy[i]);
  end

  assign sum  = prop ^ cy[W-1:0];
  assign cout = cy[W];
endmodule

// File: rtl/lut_alu.sv
module lut_alu
  import lut_alu_pkg::*;
#(
  parameter int W     = 8,
  parameter int NUSER = 4,
  localparam int FW   = NSTAT + NUSER
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  a_in,
  input  logic [W-1:0]  b_in,
  input  logic          a_clr,
  input  logic          a_inv,
  input  logic          b_clr,
  input  logic          b_inv,
  input  logic [3:0]    fn,
  input  logic          arith,
  input  logic [1:0]    cin_mode,
  input  logic          flag_we,
  input  logic [NUSER-1:0] user_flags,
  output logic [W-1:0]  result,
  output logic [FW-1:0] flags
);
  logic [W-1:0]     a_c, b_c, lg_y, sum;
  logic             cout, cin;
  logic [W-1:0]     res_n;
  logic [NSTAT-1:0] stat_n, stat_q;
  logic [NUSER-1:0] user_q;

  opnd_cond #(.W(W)) u_ca (.d(a_in), .clr(a_clr), .inv(a_inv), .q(a_c));
  opnd_cond #(.W(W)) u_cb (.d(b_in), .clr(b_clr), .inv(b_inv), .q(b_c));

  ttab_logic #(.W(W)) u_lg (.a(a_c), .b(b_c), .fn(fn), .y(lg_y));

  assign cin = cin_mode[1] ? stat_q[FLG_C] : cin_mode[0];

  gp_adder #(.W(W)) u_add (.a(a_c), .b(b_c), .cin(cin), .sum(sum), .cout(cout));

  always_comb begin
    res_n         = arith ? sum : lg_y;
    stat_n[FLG_C] = arith & cout;
    stat_n[FLG_V] = arith & (a_c[W-1] == b_c[W-1]) & (sum[W-1] != a_c[W-1]);
    stat_n[FLG_Z] = (res_n == '0);
    stat_n[FLG_S] = res_n[W-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      stat_q <= '0;
      user_q <= '0;
    end else begin
      result <= res_n;
      user_q <= user_flags;
      if (flag_we) stat_q <= stat_n;
    end
  end

  assign flags = {user_q, stat_q};
endmodule

// File: rtl/lut_alu_chk.sv
module lut_alu_chk (
  input logic       clk,
  input logic       rst,
  input logic       a_clr,
  input logic       a_inv,
  input logic       b_clr,
  input logic       b_inv,
  input logic       arith,
  input logic [1:0] cin_mode,
  input logic       flag_we,
  input logic [3:0] user_flags,
  input logic [7:0] result,
  input logic [7:0] flags
);
  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (rst) age <= '0;
    else if (age != 2'd2) age <= age + 2'd1;
  end
  logic live;
  assign live = (age == 2'd2);

  a_r1_reset_zero: assert property (@(posedge clk) rst |=> (result == 8'h00 && flags == 8'h00));

  a_r8_flags_hold: assert property (@(posedge clk) disable iff (rst)
    (live && !flag_we) |=> (flags[3:0] == $past(flags[3:0])));

  a_r7_logic_cv_clear: assert property (@(posedge clk) disable iff (rst)
    (live && flag_we && !arith) |=> (flags[0] == 1'b0 && flags[3] == 1'b0));

  a_r6_zero_sign: assert property (@(posedge clk) disable iff (rst)
    (live && flag_we) |=> (flags[1] == (result == 8'h00) && flags[2] == result[7]));

  a_r9_user_sample: assert property (@(posedge clk) disable iff (rst)
    live |=> (flags[7:4] == $past(user_flags)));

  a_r3_cleared_sum_zero: assert property (@(posedge clk) disable iff (rst)
    (live && arith && a_clr && !a_inv && b_clr && !b_inv && cin_mode == 2'b00)
    |=> (result == 8'h00));
endmodule

bind lut_alu lut_alu_chk u_chk (
  .clk(clk), .rst(rst), .a_clr(a_clr), .a_inv(a_inv), .b_clr(b_clr), .b_inv(b_inv),
  .arith(arith), .cin_mode(cin_mode), .flag_we(flag_we), .user_flags(user_flags),
  .result(result), .flags(flags)
);

// File: tb/lut_alu_test.sv
module lut_alu_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] a_in = '0, b_in = '0;
  logic       a_clr = 0, a_inv = 0, b_clr = 0, b_inv = 0;
  logic [3:0] fn = '0;
  logic       arith = 0;
  logic [1:0] cin_mode = '0;
  logic       flag_we = 0;
  logic [3:0] user_flags = '0;
  logic [7:0] result, flags;

  int tests = 0, fails = 0, cycles = 0;
  bit done = 0;
  logic [3:0] m_stat = '0;

  always #10 clk = ~clk;

  lut_alu uut (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in), .a_clr(a_clr), .a_inv(a_inv),
    .b_clr(b_clr), .b_inv(b_inv), .fn(fn), .arith(arith), .cin_mode(cin_mode),
    .flag_we(flag_we), .user_flags(user_flags), .result(result), .flags(flags)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] cond(input logic [7:0] x, input logic c, input logic i);
    if (c && i) return 8'hFF;
    if (c) return 8'h00;
    if (i) return ~x;
    return x;
  endfunction

  // Drives one operation at a falling edge, checks at the next falling edge.
  task automatic op(input logic [7:0] aa, input logic [7:0] bb, input logic ac, input logic ai,
                    input logic bc, input logic bi, input logic [3:0] f, input logic ar,
                    input logic [1:0] cm, input logic we, input logic [3:0] uf,
                    input string rtag, output logic [7:0] got);
    logic [7:0] ca, cb, r;
    logic [8:0] s9;
    logic cin, c, v;
    logic [3:0] nstat;
    ca = cond(aa, ac, ai);
    cb = cond(bb, bc, bi);
    cin = cm[1] ? m_stat[0] : cm[0];
    s9 = {1'b0, ca} + {1'b0, cb} + {8'b0, cin};
    if (ar) begin
      r = s9[7:0];
      c = s9[8];
      v = (ca[7] == cb[7]) && (r[7] != ca[7]);
    end else begin
      for (int i = 0; i < 8; i++) r[i] = f[{ca[i], cb[i]}];
      c = 0;
      v = 0;
    end
    nstat = we ? {v, r[7], (r == 8'h00), c} : m_stat;
    a_in = aa; b_in = bb; a_clr = ac; a_inv = ai; b_clr = bc; b_inv = bi;
    fn = f; arith = ar; cin_mode = cm; flag_we = we; user_flags = uf;
    @(negedge clk);
    chk(rtag, {8'h0, result}, {8'h0, r});
    if (we) begin
      chk(ar ? "R5 carry/overflow" : "R7 carry/overflow clear",
          {14'h0, flags[3], flags[0]}, {14'h0, v, c});
      chk("R6 zero/sign", {14'h0, flags[2:1]}, {14'h0, nstat[2:1]});
    end else begin
      chk("R8 flags held", {12'h0, flags[3:0]}, {12'h0, m_stat});
    end
    chk("R9 user flags", {12'h0, flags[7:4]}, {12'h0, uf});
    m_stat = nstat;
    got = result;
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000 && !done) begin
        fails++;
        tests++;
        $display("FAIL watchdog: actual %0d cycles expected < 190000", cycles);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] g, lo, hi, v8;
    logic [3:0] k;
    repeat (3) @(negedge clk);
    chk("R1 reset result", {8'h0, result}, 16'h0);
    chk("R1 reset flags", {8'h0, flags}, 16'h0);
    rst = 1'b0;

    // R4 R5 R6: full add sweep, carry-in zero
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        op(a[7:0], b[7:0], 0, 0, 0, 0, 4'h0, 1, 2'b00, 1, a[3:0], "R4 add", g);

    // R4: carry-in one and stored-carry modes
    for (int a = 0; a < 256; a += 7)
      for (int b = 0; b < 256; b += 11) begin
        op(a[7:0], b[7:0], 0, 0, 0, 0, 4'h0, 1, 2'b01, 1, b[3:0], "R4 add cin one", g);
        op(b[7:0], a[7:0], 0, 0, 0, 0, 4'h0, 1, 2'b11, 1, a[7:4], "R4 add stored cin", g);
      end

    // R2 R3: truth-table functions with varied conditioning
    for (int f = 0; f < 16; f++)
      for (int a = 0; a < 256; a += 17)
        for (int b = 0; b < 256; b += 15) begin
          k = 4'(a + b + f);
          op(a[7:0], b[7:0], k[0] & k[1], k[2], k[1] & k[3], k[0] ^ k[3], f[3:0], 0,
             2'b00, 1, f[3:0], "R2 truth table", g);
        end

    // R3: every conditioning combination, seen through pass-through functions and the adder
    for (int m = 0; m < 16; m++) begin
      op(8'h5A, 8'hC3, m[0], m[1], m[2], m[3], 4'b1100, 0, 2'b00, 1, 4'h3, "R3 pass A", g);
      chk("R3 cond A", {8'h0, g}, {8'h0, cond(8'h5A, m[0], m[1])});
      op(8'h5A, 8'hC3, m[0], m[1], m[2], m[3], 4'b1010, 0, 2'b00, 1, 4'hC, "R3 pass B", g);
      chk("R3 cond B", {8'h0, g}, {8'h0, cond(8'hC3, m[2], m[3])});
      op(8'h5A, 8'hC3, m[0], m[1], m[2], m[3], 4'h0, 1, 2'b00, 1, 4'h5, "R3 add cond", g);
    end

    // R11: subtraction sweep
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b += 5) begin
        op(a[7:0], b[7:0], 0, 0, 0, 1, 4'h0, 1, 2'b01, 1, 4'h9, "R11 subtract", g);
        chk("R11 no-borrow carry", {15'h0, flags[0]}, {15'h0, (a >= b)});
      end

    // R10: 16-bit chained add
    for (int n = 0; n < 300; n++) begin
      automatic logic [15:0] x = 16'(n * 16'd2731 + 16'd517);
      automatic logic [15:0] y = 16'(n * 16'd40503 + 16'd91);
      op(x[7:0], y[7:0], 0, 0, 0, 0, 4'h0, 1, 2'b00, 1, 4'h1, "R10 low add", lo);
      op(x[15:8], y[15:8], 0, 0, 0, 0, 4'h0, 1, 2'b10, 1, 4'h2, "R10 high adc", hi);
      chk("R10 16-bit sum", {hi, lo}, x + y);
    end

    // R10: decrement by adding 0xFF, zero flag at the end
    v8 = 8'd5;
    for (int n = 5; n > 0; n--) begin
      op(v8, 8'hFF, 0, 0, 0, 0, 4'h0, 1, 2'b00, 1, 4'h0, "R10 decrement", v8);
      chk("R10 decrement zero flag", {15'h0, flags[1]}, {15'h0, (n == 1)});
    end

    // R8: flag writes disabled, result still moves
    op(8'hF0, 8'h20, 0, 0, 0, 0, 4'h0, 1, 2'b00, 1, 4'h6, "R8 setup", g);
    op(8'h01, 8'h01, 0, 0, 0, 0, 4'h0, 1, 2'b00, 0, 4'hA, "R8 result updates", g);
    op(8'h00, 8'h00, 0, 0, 0, 0, 4'h6, 0, 2'b00, 0, 4'h5, "R8 logic no write", g);
    op(8'h80, 8'h80, 0, 0, 0, 0, 4'h0, 1, 2'b00, 0, 4'hF, "R8 overflow no write", g);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule